// File: doc/BRIEF.md
# Packed INT4 to INT8 Lookup Expander

This block converts vectors of packed 4-bit weight codes into signed 8-bit values for an INT8 multiply array. Every input byte holds two codes. Each code is an unsigned index into a programmable 16-entry table of signed bytes, and the selected entry becomes the expanded element. A single input vector of `VEC_BYTES` bytes therefore yields `2*VEC_BYTES` elements. They leave the block as two output vectors of `VEC_BYTES` bytes each, lower half first.

Weights are grouped in blocks of `BLK_ELEMS` elements, and each block carries one 16-bit scale word. The block does no arithmetic on the scale words. It presents each one on a sideband output together with the output vector that holds that block's elements. At acceptance the block captures the input vector, its scales and a snapshot of the whole table. Table writes made after that point therefore affect only later vectors.

Top module: `int4_lut_expander`

## Requirements
- R1: After reset, `out_valid_o` is 0, `in_ready_o` is 1, and table entry c holds the signed byte c-8, so code 0 maps to -8 (0xF8) and code 15 maps to +7 (0x07).
- R2: Within input byte i, bits 3:0 are element 2i and bits 7:4 are element 2i+1.
- R3: Each output element is the 8-bit table entry addressed by its 4-bit code. Element j of an output vector occupies bits 8j+7:8j.
- R4: When `tbl_we_i` is high at a clock edge, entry `tbl_addr_i` takes `tbl_data_i`, one entry per cycle. Every vector accepted at a later edge uses the new value.
- R5: A vector is converted with the table as it stood before its accept edge. A write in the same cycle as the accept, or during any cycle while the vector is held, does not change that vector's output.
- R6: An accepted vector produces two output vectors. The first carries input bytes 0 to VEC_BYTES/2-1 with `out_half_o`=0, and the second carries the remaining bytes with `out_half_o`=1. Elements ascend in index within each vector.
- R7: `in_scale_i` holds block b's scale at bits 16b+15:16b, with block b covering elements b*BLK_ELEMS onward. `out_scale_o` carries the scales of the blocks in the current output vector, lowest block in the low 16 bits.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_half_o`, `out_data_o` and `out_scale_o` stay unchanged.
- R9: `in_ready_o` is low from the accept edge until the edge at which the second output vector is consumed, and it is high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 4 | Table entry index |
| tbl_data_i | input | 8 | Signed value written to the entry |
| in_valid_i | input | 1 | Input vector valid |
| in_ready_o | output | 1 | Block can accept an input vector |
| in_data_i | input | 8*VEC_BYTES | Packed 4-bit codes, two per byte |
| in_scale_i | input | 32*VEC_BYTES/BLK_ELEMS | One 16-bit scale per block |
| out_valid_o | output | 1 | Output vector valid |
| out_ready_i | input | 1 | Consumer takes the output vector |
| out_half_o | output | 1 | 0 for the first output vector, 1 for the second |
| out_data_o | output | 8*VEC_BYTES | Expanded signed 8-bit elements |
| out_scale_o | output | 16*VEC_BYTES/BLK_ELEMS | Scales of the blocks in this output vector |

## Verification
The assertions take for granted that every control input (`tbl_we_i`, `in_valid_i`, `out_ready_i`) carries a known value at each edge after reset. They also assume the table address is always a defined 4-bit value whenever a write is enabled. The stimulus drives every input to a defined level on the falling edge, before any rising edge samples it. It holds `out_ready_i` low for several cycles to exercise back-pressure. It places table writes in the accept cycle and in stalled cycles, which are the only orderings where the snapshot rule matters.

// File: rtl/int4_lut_pkg.sv
`timescale 1ns/1ps
package int4_lut_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned LUT_N  = 1 << CODE_W;
  localparam int unsigned ELEM_W = 8;

  typedef logic [ELEM_W-1:0] elem_t;
  typedef logic [LUT_N-1:0][ELEM_W-1:0] lut_t;

  // default map: code c -> c - 8
  function automatic elem_t reset_entry(input int unsigned c);
    return elem_t'(c) - elem_t'(8);
  endfunction
endpackage

// File: rtl/int4_lut_table.sv
`timescale 1ns/1ps
module int4_lut_table
  import int4_lut_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] addr_i,
  input  elem_t             data_i,
  output lut_t              table_o
);
  lut_t entries_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < int'(LUT_N); c++) entries_q[c] <= reset_entry(c);
    end else if (we_i) begin
      entries_q[addr_i] <= data_i;
    end
  end

  assign table_o = entries_q;

  assert_tbl_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> table_o[$past(addr_i)] == $past(data_i));
  assert_tbl_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(table_o));
endmodule

// File: rtl/int4_hold_stage.sv
`timescale 1ns/1ps
module int4_hold_stage
  import int4_lut_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 64,
  parameter int unsigned SCALE_BITS = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [8*VEC_BYTES-1:0] in_data_i,
  input  logic [SCALE_BITS-1:0]  in_scale_i,
  input  lut_t                   table_i,
  input  logic                   out_ready_i,
  output logic                   out_valid_o,
  output logic                   out_half_o,
  output logic [8*VEC_BYTES-1:0] data_o,
  output logic [SCALE_BITS-1:0]  scale_o,
  output lut_t                   snap_o
);
  logic full_q, half_q, accept, take;
  logic [8*VEC_BYTES-1:0] data_q;
  logic [SCALE_BITS-1:0]  scale_q;
  lut_t                   snap_q;

  assign in_ready_o = !full_q;
  assign accept     = in_valid_i && !full_q;
  assign take       = full_q && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      half_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      half_q <= 1'b0;
    end else if (take) begin
      half_q <= !half_q;
      if (half_q) full_q <= 1'b0;
    end
  end

  // payload and table snapshot captured together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      scale_q <= '0;
      snap_q  <= '0;
    end else if (accept) begin
      data_q  <= in_data_i;
      scale_q <= in_scale_i;
      snap_q  <= table_i;
    end
  end

  assign out_valid_o = full_q;
  assign out_half_o  = half_q;
  assign data_o      = data_q;
  assign scale_o     = scale_q;
  assign snap_o      = snap_q;

  assert_snap_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> $stable(snap_o) || $past(!out_valid_o || (out_half_o && out_ready_i)));
  assert_first_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o && !out_half_o);
  assert_second_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !out_half_o) |=> out_valid_o && out_half_o);
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_half_o) |=> in_ready_o && !out_valid_o);
endmodule

// File: rtl/int4_nibble_expand.sv
`timescale 1ns/1ps
module int4_nibble_expand
  import int4_lut_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 64
) (
  input  logic [8*VEC_BYTES-1:0] data_i,
  input  logic                   half_i,
  input  lut_t                   table_i,
  output logic [8*VEC_BYTES-1:0] elems_o
);
  localparam int unsigned HALF_W = 4 * VEC_BYTES;

  logic [HALF_W-1:0] src;
  assign src = half_i ? data_i[2*HALF_W-1:HALF_W] : data_i[HALF_W-1:0];

  for (genvar j = 0; j < int'(VEC_BYTES); j++) begin : g_elem
    logic [CODE_W-1:0] code;
    if (j % 2 == 0) begin : g_lo
      assign code = src[8*(j/2) +: CODE_W];
    end else begin : g_hi
      assign code = src[8*(j/2) + CODE_W +: CODE_W];
    end
    assign elems_o[ELEM_W*j +: ELEM_W] = table_i[code];
  end
endmodule

// File: rtl/int4_lut_expander.sv
`timescale 1ns/1ps
module int4_lut_expander
  import int4_lut_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 64,
  parameter int unsigned BLK_ELEMS = 32,
  parameter int unsigned SCALE_W   = 16
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     tbl_we_i,
  input  logic [CODE_W-1:0]                        tbl_addr_i,
  input  logic [ELEM_W-1:0]                        tbl_data_i,
  input  logic                                     in_valid_i,
  output logic                                     in_ready_o,
  input  logic [8*VEC_BYTES-1:0]                   in_data_i,
  input  logic [2*VEC_BYTES/BLK_ELEMS*SCALE_W-1:0] in_scale_i,
  output logic                                     out_valid_o,
  input  logic                                     out_ready_i,
  output logic                                     out_half_o,
  output logic [8*VEC_BYTES-1:0]                   out_data_o,
  output logic [VEC_BYTES/BLK_ELEMS*SCALE_W-1:0]   out_scale_o
);
  localparam int unsigned NBLK       = 2 * VEC_BYTES / BLK_ELEMS;
  localparam int unsigned HALF_SC_W  = (NBLK / 2) * SCALE_W;
  localparam int unsigned SCALE_BITS = NBLK * SCALE_W;

  lut_t                   table_w, snap_w;
  logic [8*VEC_BYTES-1:0] data_w;
  logic [SCALE_BITS-1:0]  scale_w;

  int4_lut_table u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .addr_i  (tbl_addr_i),
    .data_i  (tbl_data_i),
    .table_o (table_w)
  );

  int4_hold_stage #(.VEC_BYTES(VEC_BYTES), .SCALE_BITS(SCALE_BITS)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .in_scale_i  (in_scale_i),
    .table_i     (table_w),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_half_o  (out_half_o),
    .data_o      (data_w),
    .scale_o     (scale_w),
    .snap_o      (snap_w)
  );

  int4_nibble_expand #(.VEC_BYTES(VEC_BYTES)) u_expand (
    .data_i  (data_w),
    .half_i  (out_half_o),
    .table_i (snap_w),
    .elems_o (out_data_o)
  );

  assign out_scale_o = out_half_o ? scale_w[SCALE_BITS-1:HALF_SC_W] : scale_w[HALF_SC_W-1:0];

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_half_o)
      && $stable(out_data_o) && $stable(out_scale_o));
  assert_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !(out_ready_i && out_half_o)) |=> !in_ready_o);
endmodule

// File: tb/int4_lut_expander_tb.sv
`timescale 1ns/1ps
module int4_lut_expander_tb;
  localparam int VB = 64;
  localparam int W  = 8 * VB;

  logic          clk_i = 0, rst_ni = 0;
  logic          tbl_we_i = 0;
  logic [3:0]    tbl_addr_i = 0;
  logic [7:0]    tbl_data_i = 0;
  logic          in_valid_i = 0, in_ready_o;
  logic [W-1:0]  in_data_i = '0;
  logic [63:0]   in_scale_i = '0;
  logic          out_valid_o, out_ready_i = 0, out_half_o;
  logic [W-1:0]  out_data_o;
  logic [31:0]   out_scale_o;

  int checks = 0, failures = 0;
  logic [7:0] tbl_m [16];
  logic [7:0] snap  [16];

  always #2.5 clk_i = !clk_i;

  int4_lut_expander u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_vec(input logic [W-1:0] d, input int h);
    logic [W-1:0] r;
    for (int j = 0; j < VB; j++) begin
      int g = h * VB + j;
      logic [7:0] b = d[8*(g/2) +: 8];
      logic [3:0] c = (g % 2 == 1) ? b[7:4] : b[3:0];
      r[8*j +: 8] = snap[c];
    end
    return r;
  endfunction

  task automatic tbl_write(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk_i);
    tbl_we_i = 1; tbl_addr_i = a; tbl_data_i = v; tbl_m[a] = v;
  endtask

  // accept one vector; optional table write in the accept cycle
  task automatic send(input logic [W-1:0] d, input logic [63:0] s, input bit wr, input logic [3:0] wa, input logic [7:0] wd);
    @(negedge clk_i);
    tbl_we_i = 0;
    chk(in_ready_o === 1'b1, "R9 ready before accept", W'(in_ready_o), W'(1));
    in_valid_i = 1; in_data_i = d; in_scale_i = s;
    for (int c = 0; c < 16; c++) snap[c] = tbl_m[c];
    if (wr) begin tbl_we_i = 1; tbl_addr_i = wa; tbl_data_i = wd; tbl_m[wa] = wd; end
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 0; tbl_we_i = 0;
  endtask

  task automatic recv(input logic [W-1:0] d, input logic [63:0] s, input int stall, input bit wr_mid, input logic [3:0] wa, input logic [7:0] wd);
    for (int h = 0; h < 2; h++) begin
      logic [W-1:0] first = out_data_o;
      for (int k = 0; k < stall; k++) begin
        chk(out_valid_o === 1'b1 && out_half_o === h[0] && out_data_o === first,
            "R8 stall hold", out_data_o, first);
        chk(in_ready_o === 1'b0, "R9 busy", W'(in_ready_o), W'(0));
        if (wr_mid && k == 0) begin tbl_we_i = 1; tbl_addr_i = wa; tbl_data_i = wd; tbl_m[wa] = wd; end
        @(posedge clk_i);
        @(negedge clk_i);
        tbl_we_i = 0;
      end
      chk(out_valid_o === 1'b1 && out_half_o === h[0], "R6 half order", W'({out_valid_o, out_half_o}), W'({1'b1, h[0]}));
      chk(out_data_o === exp_vec(d, h), "R2 R3 R5 elements", out_data_o, exp_vec(d, h));
      chk(out_scale_o === s[32*h +: 32], "R7 scale", W'(out_scale_o), W'(s[32*h +: 32]));
      out_ready_i = 1;
      @(posedge clk_i);
      @(negedge clk_i);
      out_ready_i = 0;
    end
    chk(in_ready_o === 1'b1 && out_valid_o === 1'b0, "R9 release", W'({in_ready_o, out_valid_o}), W'(2'b10));
  endtask

  function automatic logic [W-1:0] pat(input int mul, input int seed);
    logic [W-1:0] r;
    for (int i = 0; i < VB; i++) r[8*i +: 8] = 8'((i * mul + seed) & 255);
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 16; c++) tbl_m[c] = 8'(c - 8);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(in_ready_o === 1'b1 && out_valid_o === 1'b0, "R1 reset state", W'({in_ready_o, out_valid_o}), W'(2'b10));

    // R1 R2 R3: default table, all 256 byte values across four vectors
    for (int v = 0; v < 4; v++) begin
      logic [W-1:0] d = pat(1, 64 * v);
      logic [63:0]  s = {16'(v*4+3), 16'(v*4+2), 16'(v*4+1), 16'(v*4)} ^ 64'hA5A5_0F0F_3C3C_9999;
      send(d, s, 0, 0, 0);
      recv(d, s, v, 0, 0, 0);
    end

    // R4: rewrite whole table back to back, then sweep again
    for (int c = 0; c < 16; c++) tbl_write(4'(c), 8'((c * 37 + 11) & 255));
    for (int v = 0; v < 4; v++) begin
      logic [W-1:0] d = pat(7, 64 * v + 5);
      logic [63:0]  s = {16'hBEEF, 16'(v), 16'hC0DE, 16'(v + 100)};
      send(d, s, 0, 0, 0);
      recv(d, s, 1, 0, 0, 0);
    end

    // R5: write in the accept cycle, then a later vector sees it (R4)
    begin
      logic [W-1:0] d = pat(0, 8'h33);
      send(d, 64'h1111_2222_3333_4444, 1, 4'd3, 8'h5A);
      recv(d, 64'h1111_2222_3333_4444, 0, 0, 0, 0);
      send(d, 64'h0, 0, 0, 0);
      recv(d, 64'h0, 0, 0, 0, 0);
      chk(exp_vec(d, 0)[7:0] === 8'h5A, "R4 new entry used", W'(exp_vec(d, 0)[7:0]), W'(8'h5A));
    end

    // R5: write while the vector is held
    begin
      logic [W-1:0] d = pat(3, 1);
      send(d, 64'hFEDC_BA98_7654_3210, 0, 0, 0);
      recv(d, 64'hFEDC_BA98_7654_3210, 2, 1, 4'd1, 8'h81);
      send(d, 64'h0123, 0, 0, 0);
      recv(d, 64'h0123, 0, 0, 0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule